// File: doc/BRIEF.md
# Sign-filling right shifter with selectable control style

This block shifts a data word right by a chosen distance and fills each vacated upper position with a copy of the word's top bit, so a two's-complement value keeps its sign. It has no storage: the result follows the inputs in the same cycle and can sit inside any datapath stage.

A build-time parameter selects one of two ways to give the shift distance. In the one-hot style, each control line stands for one distance, and every output bit is an OR of pass terms taken from the input bits that the line selects. A control vector with no line set, or with more than one set, is flagged and the data output is held at zero. In the staged style, the control is a binary distance. The word passes through a cascade of stages that each move it by a power of two. Both styles give the same word for the same distance.

Top module: `arith_rshift`

## Requirements
- R1: With the distance at zero (one-hot line 0, or binary value 0), `result_o` equals `data_i` unchanged.
- R2: For a distance k from 0 to WIDTH-1, `result_o[WIDTH-1-k:0]` equals `data_i[WIDTH-1:k]`. This matches a signed arithmetic right shift by k.
- R3: The k upper bits of `result_o` left empty by a shift of k all equal `data_i[WIDTH-1]`: ones for a negative word, zeros for a non-negative one.
- R4: In the one-hot style (STYLE = STYLE_BARREL), bit k of `ctrl_i` selects distance k. When exactly one bit is set, `err_o` is 0.
- R5: In the one-hot style, if `ctrl_i` has no bit set or has two or more bits set, `err_o` is 1 and `result_o` is all zeros, whatever `data_i` holds.
- R6: In the staged style (STYLE = STYLE_LOG), `ctrl_i` is an unsigned binary distance $clog2(WIDTH) bits wide, and bit s of it moves the word by 2^s positions. `err_o` is always 0.
- R7: For equal distances, the two styles produce identical `result_o` for every value of `data_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | WIDTH | Word to be shifted; bit WIDTH-1 is the sign |
| ctrl_i | input | WIDTH (one-hot style) or $clog2(WIDTH) (staged style) | Shift distance: one line per distance, or a binary value |
| result_o | output | WIDTH | Shifted word with sign fill; zero on a control error |
| err_o | output | 1 | Control vector not one-hot (one-hot style only) |

## Verification
The block has no state, so any fault shows on the ports in the same cycle as the stimulus that exposes it. A miswired matrix column or stage shows up as one output bit taking the wrong neighbour at one particular distance. A fault in the fill logic shows up as wrong upper bits, and only for words with the sign bit set. A fault in the one-hot detector shows up as a raised `err_o`, or as a nonzero word passing through, only for control vectors with zero or several bits set. For this reason every data value is applied at every distance in both styles, and the illegal control patterns are driven on their own.

// File: rtl/ars_pkg.sv
package ars_pkg;
  typedef enum logic {
    STYLE_BARREL = 1'b0,
    STYLE_LOG    = 1'b1
  } style_e;

  function automatic int unsigned ctrl_width(int unsigned w, style_e st);
    return (st == STYLE_BARREL) ? w : $clog2(w);
  endfunction
endpackage

// File: rtl/ars_onehot.sv
// Flags a vector with exactly one bit set, via running "seen"/"multi" chain.
module ars_onehot #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] vec_i,
  output logic         ok_o
);
  logic [N:0] seen;
  logic [N:0] multi;

  assign seen[0]  = 1'b0;
  assign multi[0] = 1'b0;

  for (genvar k = 0; k < N; k++) begin : g_chain
    assign seen[k+1]  = seen[k] | vec_i[k];
    assign multi[k+1] = multi[k] | (seen[k] & vec_i[k]);
  end

  assign ok_o = seen[N] & ~multi[N];
endmodule

// File: rtl/ars_barrel.sv
// Pass-switch matrix: output bit i ORs ext[i+k] gated by select line k.
module ars_barrel #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [WIDTH-1:0] sel_i,
  output logic [WIDTH-1:0] data_o
);
  localparam int unsigned EXT_W = 2 * WIDTH;

  logic [EXT_W-1:0] ext;
  assign ext = {{WIDTH{data_i[WIDTH-1]}}, data_i};

  for (genvar i = 0; i < WIDTH; i++) begin : g_row
    logic [WIDTH-1:0] col;
    for (genvar k = 0; k < WIDTH; k++) begin : g_sw
      assign col[k] = ext[i+k];
    end
    assign data_o[i] = |(col & sel_i);
  end
endmodule

// File: rtl/ars_log.sv
// Cascade of power-of-two stages; stage s moves by 2**s when amt_i[s] is set.
module ars_log #(
  parameter int unsigned WIDTH = 8,
  localparam int unsigned SH_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [SH_W-1:0]  amt_i,
  output logic [WIDTH-1:0] data_o
);
  logic [WIDTH-1:0] stg [SH_W+1];

  assign stg[0] = data_i;

  for (genvar s = 0; s < SH_W; s++) begin : g_stage
    localparam int unsigned D = 1 << s;
    logic [WIDTH-1:0] moved;
    assign moved      = {{D{stg[s][WIDTH-1]}}, stg[s][WIDTH-1:D]};
    assign stg[s+1]   = amt_i[s] ? moved : stg[s];
  end

  assign data_o = stg[SH_W];
endmodule

// File: rtl/arith_rshift.sv
module arith_rshift #(
  parameter int unsigned     WIDTH  = 8,
  parameter ars_pkg::style_e STYLE  = ars_pkg::STYLE_BARREL,
  localparam int unsigned    CTRL_W = ars_pkg::ctrl_width(WIDTH, STYLE)
) (
  input  logic [WIDTH-1:0]  data_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic [WIDTH-1:0]  result_o,
  output logic              err_o
);
  if (STYLE == ars_pkg::STYLE_BARREL) begin : g_barrel
    logic [WIDTH-1:0] raw;
    logic             sel_ok;

    ars_onehot #(.N(WIDTH)) i_onehot (
      .vec_i (ctrl_i),
      .ok_o  (sel_ok)
    );

    ars_barrel #(.WIDTH(WIDTH)) i_matrix (
      .data_i (data_i),
      .sel_i  (ctrl_i),
      .data_o (raw)
    );

    assign result_o = sel_ok ? raw : '0;
    assign err_o    = ~sel_ok;
  end else begin : g_log
    ars_log #(.WIDTH(WIDTH)) i_stages (
      .data_i (data_i),
      .amt_i  (ctrl_i),
      .data_o (result_o)
    );
    assign err_o = 1'b0;
  end
endmodule

// File: rtl/ars_checker.sv
module ars_checker #(
  parameter int unsigned     WIDTH  = 8,
  parameter ars_pkg::style_e STYLE  = ars_pkg::STYLE_BARREL,
  localparam int unsigned    CTRL_W = ars_pkg::ctrl_width(WIDTH, STYLE)
) (
  input logic [WIDTH-1:0]  data_i,
  input logic [CTRL_W-1:0] ctrl_i,
  input logic [WIDTH-1:0]  result_o,
  input logic              err_o
);
  int unsigned amt;
  int unsigned ones;

  always_comb begin
    amt  = 0;
    ones = 0;
    if (STYLE == ars_pkg::STYLE_BARREL) begin
      for (int k = 0; k < WIDTH; k++) begin
        if (ctrl_i[k]) begin
          amt  = k;
          ones = ones + 1;
        end
      end
    end else begin
      amt  = int'(ctrl_i);
      ones = 1;
    end
  end

  always_comb begin
    if (STYLE == ars_pkg::STYLE_BARREL) begin
      p_err_onehot_r4: assert (err_o == (ones != 1))
        else $error("err_o does not match one-hot status of ctrl_i");
    end else begin
      p_log_noerr_r6: assert (!err_o)
        else $error("staged style raised err_o");
    end
    if (err_o) begin
      p_err_zero_r5: assert (result_o == '0)
        else $error("result not zero under control error");
    end else begin
      if (amt == 0) begin
        p_pass_r1: assert (result_o == data_i)
          else $error("zero distance altered the word");
      end
      for (int i = 0; i < WIDTH; i++) begin
        if (i + amt >= WIDTH) begin
          p_sign_fill_r3: assert (result_o[i] == data_i[WIDTH-1])
            else $error("vacated bit %0d not sign filled", i);
        end else begin
          p_move_r2: assert (result_o[i] == data_i[i+amt])
            else $error("bit %0d took wrong source", i);
        end
      end
    end
  end
endmodule

bind arith_rshift ars_checker #(.WIDTH(WIDTH), .STYLE(STYLE)) i_chk (
  .data_i   (data_i),
  .ctrl_i   (ctrl_i),
  .result_o (result_o),
  .err_o    (err_o)
);

// File: tb/test_arith_rshift.sv
module test_arith_rshift;
  localparam int CLK_P = 10;
  localparam int W     = 8;
  localparam int SW    = 3;
  localparam int NVEC  = 8;
  // {data, distance, expected}
  localparam logic [18:0] VEC [NVEC] = '{
    {8'h96, 3'd0, 8'h96},
    {8'h96, 3'd1, 8'hCB},
    {8'h96, 3'd3, 8'hF2},
    {8'h96, 3'd7, 8'hFF},
    {8'h5A, 3'd2, 8'h16},
    {8'h5A, 3'd7, 8'h00},
    {8'h80, 3'd4, 8'hF8},
    {8'h7F, 3'd6, 8'h01}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic [W-1:0]  data;
  logic [W-1:0]  sel_b;
  logic [SW-1:0] amt_l;
  logic [W-1:0]  res_b, res_l;
  logic          err_b, err_l;

  int checks = 0;
  int errors = 0;

  arith_rshift #(.WIDTH(W), .STYLE(ars_pkg::STYLE_BARREL)) i_arith_rshift (
    .data_i (data), .ctrl_i (sel_b), .result_o (res_b), .err_o (err_b)
  );

  arith_rshift #(.WIDTH(W), .STYLE(ars_pkg::STYLE_LOG)) i_arith_rshift_log (
    .data_i (data), .ctrl_i (amt_l), .result_o (res_l), .err_o (err_l)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (data=%h sel=%h amt=%0d)",
               req, act, exp, data, sel_b, amt_l);
    end
  endtask

  task automatic apply(input logic [W-1:0] d, input logic [W-1:0] s, input logic [SW-1:0] a);
    @(posedge clk);
    data  <= d;
    sel_b <= s;
    amt_l <= a;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    data = '0; sel_b = '0; amt_l = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state: all-zero one-hot control is illegal
    chk("R5 idle err", {7'd0, err_b}, 8'd1);
    chk("R5 idle result", res_b, 8'h00);
    chk("R6 idle log err", {7'd0, err_l}, 8'd0);

    for (int n = 0; n < NVEC; n++) begin
      logic [W-1:0] d, e;
      logic [SW-1:0] a;
      {d, a, e} = VEC[n];
      apply(d, 8'd1 << a, a);
      chk((a == 0) ? "R1 table barrel" : "R2 R3 table barrel", res_b, e);
      chk("R6 table log", res_l, e);
      chk("R4 table err", {7'd0, err_b}, 8'd0);
    end

    for (int d = 0; d < 256; d++) begin
      for (int a = 0; a < W; a++) begin
        logic [W-1:0] e;
        e = W'($signed(W'(d)) >>> a);
        apply(W'(d), 8'd1 << a, SW'(a));
        chk("R2 R3 sweep barrel", res_b, e);
        chk("R6 sweep log", res_l, e);
        chk("R7 styles agree", res_b, res_l);
        chk("R4 sweep err", {7'd0, err_b}, 8'd0);
        chk("R6 sweep log err", {7'd0, err_l}, 8'd0);
      end
    end

    // R1 explicit pass-through of a negative word
    apply(8'hC3, 8'h01, 3'd0);
    chk("R1 pass barrel", res_b, 8'hC3);
    chk("R1 pass log", res_l, 8'hC3);

    // R5 illegal one-hot patterns with nonzero data
    apply(8'hFF, 8'h03, 3'd0);
    chk("R5 two lines err", {7'd0, err_b}, 8'd1);
    chk("R5 two lines result", res_b, 8'h00);
    apply(8'hA5, 8'hFF, 3'd0);
    chk("R5 all lines err", {7'd0, err_b}, 8'd1);
    chk("R5 all lines result", res_b, 8'h00);
    apply(8'h81, 8'h00, 3'd0);
    chk("R5 no line err", {7'd0, err_b}, 8'd1);
    chk("R5 no line result", res_b, 8'h00);
    apply(8'h81, 8'h90, 3'd7);
    chk("R5 top pair result", res_b, 8'h00);
    chk("R6 log unaffected", res_l, 8'hFF);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule